// File: doc/BRIEF.md
# Noise Channel Pseudo-Random Bit Generator

This block produces the pseudo-random bit stream of a sound unit's noise voice. Software programs a frequency/mode byte that sets a clock shift, a 3-bit divisor code and a width flag. It then writes a trigger byte to restart the sequence. A 15-bit shift register with XNOR feedback advances each time a countdown of system ticks runs out. The width flag either keeps the full 15-bit sequence or mirrors the feedback into a lower bit, which gives a short 7-bit sequence.

The countdown first loaded at a trigger is not a whole step period. It depends on the current phase of a toggle that flips every tick, on bit 1 of a free-running tick counter, on the divisor code, and on whether the voice was already sounding. Every later step reloads a fixed period derived from the programmed byte. Ticks come in through an enable, so the block holds its state between ticks.

Top module: `noise_gen`

## Requirements
- R1: After reset the shift register, the countdown and the tick counter are zero and the phase toggle is 1, so `noiseOut` reads 1.
- R2: A trigger-byte write with bit 7 set clears the shift register, so `noiseOut` is 1 in the following cycle.
- R3: A trigger-byte write with bit 7 clear changes nothing: the step timing and the output stay as they would be without it.
- R4: The frequency byte holds the clock shift in bits 7:4, the width flag in bit 3 and the divisor code in bits 2:0. The divisor is twice the code, or 1 when the code is 0. The sample length L is (divisor << shift) - 1. After each step the countdown reloads to 4L+3, so steps occur every 4L+4 ticks.
- R5: At a trigger the countdown loads 2L+6-P, where P is the phase toggle. P is 1 after reset and inverts on every tick. A step happens on the tick that finds the countdown at 0, so the first step comes on the (2L+7-P)-th tick after the trigger.
- R6: At a trigger with a nonzero code, when bit 1 of the tick counter is 0, the first countdown is 2 ticks longer if the code is 1 and 2 ticks shorter for any other code. The tick counter is 0 after reset and advances by one on every tick. Bit 1 of the counter set, or a code of 0, gives no adjustment.
- R7: When `chanActive` is high at the trigger, the first countdown is 2 ticks longer.
- R8: A step shifts the register right by one and writes XNOR(bit 0, bit 1) into bit 14. With the width flag set it also writes that value into bit 6. `noiseOut` is the inverse of bit 0, so from a trigger it first falls after 15 steps in wide mode and after 7 steps in narrow mode.
- R9: Writing the frequency byte while running does not restart the countdown under way. The new value governs the reload and the width of later steps.
- R10: In a cycle without `tick` and without a trigger, the countdown, the shift register, the phase toggle and the tick counter hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | System tick enable; one tick per asserted cycle |
| freqWe | input | 1 | Write strobe for the frequency/mode byte |
| freqData | input | 8 | Frequency/mode byte: shift 7:4, width flag 3, code 2:0 |
| trigWe | input | 1 | Write strobe for the trigger byte |
| trigData | input | 8 | Trigger byte; bit 7 restarts the sequence |
| chanActive | input | 1 | High while the voice is already sounding |
| noiseOut | output | 1 | Current noise bit |

## Verification
A wrong countdown, phase toggle or tick-counter bit does not corrupt the bit pattern. It moves the moment of the first output fall after a trigger by a whole number of ticks, and each wrong reload adds the same error once per step before that fall. The bench therefore counts ticks from each trigger to the first falling edge of `noiseOut`. It steers the trigger onto each of the four tick-counter phases and compares the count exactly, which exposes any off-by-one within one sequence. A wrong feedback tap or width mask changes the number of steps to that fall, from 15 or 7 to some other count.

// File: rtl/noise_pkg.sv
package noise_pkg;

  // Strobes handed from the control to the shift-register datapath
  typedef struct packed {
    logic load;    // restart: clear the register
    logic step;    // advance the register by one
    logic narrow;  // mirror feedback into the short-sequence bit
  } lfsrCtl_t;

endpackage

// File: rtl/noise_period.sv
module noise_period #(
  parameter int CODE_W  = 3,
  parameter int SHIFT_W = 4,
  parameter int LEN_W   = 19
) (
  input  logic [CODE_W-1:0]  code,
  input  logic [SHIFT_W-1:0] shiftAmt,
  output logic [LEN_W-1:0]   sampleLen
);

  localparam int DIV_W = CODE_W + 1;

  logic [DIV_W-1:0] divisor;

  always_comb begin
    divisor   = (code == '0) ? DIV_W'(1) : {code, 1'b0};
    sampleLen = (LEN_W'(divisor) << shiftAmt) - LEN_W'(1);
  end

endmodule

// File: rtl/noise_ctrl.sv
module noise_ctrl
  import noise_pkg::*;
#(
  parameter int CODE_W  = 3,
  parameter int SHIFT_W = 4,
  parameter int LEN_W   = 19,
  parameter int CNT_W   = 22,
  parameter int ALIGN_W = 8,
  parameter int REG_W   = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               tick,
  input  logic               freqWe,
  input  logic [REG_W-1:0]   freqData,
  input  logic               trigWe,
  input  logic [REG_W-1:0]   trigData,
  input  logic               chanActive,
  input  logic [LEN_W-1:0]   sampleLen,
  output logic [CODE_W-1:0]  codeQ,
  output logic [SHIFT_W-1:0] shiftQ,
  output lfsrCtl_t           ctl,
  output logic [CNT_W-1:0]   cntQ,
  output logic [CNT_W-1:0]   reloadVal,
  output logic [ALIGN_W-1:0] alignQ,
  output logic               phaseQ
);

  localparam int NARROW_POS = CODE_W;
  localparam int TRIG_POS   = REG_W - 1;

  logic             narrowQ;
  logic             trigHit;
  logic             codeIsOne;
  logic             codeOther;
  logic             alignLow;
  logic [CNT_W-1:0] trigInit;

  always_comb begin
    trigHit   = trigWe & trigData[TRIG_POS];
    reloadVal = CNT_W'({sampleLen, 2'b11});
    codeIsOne = (codeQ == CODE_W'(1));
    codeOther = (codeQ != '0) & ~codeIsOne;
    alignLow  = ~alignQ[1];
    trigInit  = CNT_W'({sampleLen, 1'b0}) + CNT_W'(6) - CNT_W'(phaseQ);
    if (alignLow && codeIsOne) trigInit = trigInit + CNT_W'(2);
    if (alignLow && codeOther) trigInit = trigInit - CNT_W'(2);
    if (chanActive)            trigInit = trigInit + CNT_W'(2);
    ctl.load   = trigHit;
    ctl.step   = tick & ~trigHit & (cntQ == '0);
    ctl.narrow = narrowQ;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      codeQ   <= '0;
      shiftQ  <= '0;
      narrowQ <= 1'b0;
      cntQ    <= '0;
      alignQ  <= '0;
      phaseQ  <= 1'b1;
    end else begin
      if (freqWe) begin
        codeQ   <= freqData[CODE_W-1:0];
        narrowQ <= freqData[NARROW_POS];
        shiftQ  <= freqData[REG_W-1:NARROW_POS+1];
      end
      if (tick) begin
        alignQ <= alignQ + ALIGN_W'(1);
        phaseQ <= ~phaseQ;
      end
      if (trigHit) begin
        cntQ <= trigInit;
      end else if (tick) begin
        cntQ <= (cntQ == '0) ? reloadVal : cntQ - CNT_W'(1);
      end
    end
  end

endmodule

// File: rtl/noise_lfsr.sv
module noise_lfsr
  import noise_pkg::*;
#(
  parameter int LFSR_W     = 15,
  parameter int NARROW_BIT = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  lfsrCtl_t          ctl,
  output logic [LFSR_W-1:0] lfsrQ
);

  logic              feedback;
  logic [LFSR_W-1:0] shifted;

  always_comb begin
    feedback            = ~(lfsrQ[0] ^ lfsrQ[1]);
    shifted             = lfsrQ >> 1;
    shifted[LFSR_W-1]   = feedback;
    if (ctl.narrow) shifted[NARROW_BIT] = feedback;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || ctl.load) lfsrQ <= '0;
    else if (ctl.step)      lfsrQ <= shifted;
  end

endmodule

// File: rtl/noise_gen.sv
module noise_gen
  import noise_pkg::*;
#(
  parameter int CODE_W     = 3,
  parameter int SHIFT_W    = 4,
  parameter int ALIGN_W    = 8,
  parameter int LFSR_W     = 15,
  parameter int NARROW_BIT = 6
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       freqWe,
  input  logic [7:0] freqData,
  input  logic       trigWe,
  input  logic [7:0] trigData,
  input  logic       chanActive,
  output logic       noiseOut
);

  localparam int REG_W = 8;
  localparam int LEN_W = CODE_W + (1 << SHIFT_W);
  localparam int CNT_W = LEN_W + 3;

  logic [CODE_W-1:0]  codeQ;
  logic [SHIFT_W-1:0] shiftQ;
  logic [LEN_W-1:0]   sampleLen;
  logic [CNT_W-1:0]   cntQ;
  logic [CNT_W-1:0]   reloadVal;
  logic [ALIGN_W-1:0] alignQ;
  logic               phaseQ;
  logic [LFSR_W-1:0]  lfsrQ;
  lfsrCtl_t           ctl;

  noise_period #(
    .CODE_W(CODE_W), .SHIFT_W(SHIFT_W), .LEN_W(LEN_W)
  ) u_period (
    .code(codeQ), .shiftAmt(shiftQ), .sampleLen(sampleLen)
  );

  noise_ctrl #(
    .CODE_W(CODE_W), .SHIFT_W(SHIFT_W), .LEN_W(LEN_W),
    .CNT_W(CNT_W), .ALIGN_W(ALIGN_W), .REG_W(REG_W)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n), .tick(tick),
    .freqWe(freqWe), .freqData(freqData),
    .trigWe(trigWe), .trigData(trigData), .chanActive(chanActive),
    .sampleLen(sampleLen), .codeQ(codeQ), .shiftQ(shiftQ), .ctl(ctl),
    .cntQ(cntQ), .reloadVal(reloadVal), .alignQ(alignQ), .phaseQ(phaseQ)
  );

  noise_lfsr #(
    .LFSR_W(LFSR_W), .NARROW_BIT(NARROW_BIT)
  ) u_lfsr (
    .clk(clk), .rst_n(rst_n), .ctl(ctl), .lfsrQ(lfsrQ)
  );

  assign noiseOut = ~lfsrQ[0];

endmodule

// File: rtl/noise_gen_chk.sv
module noise_gen_chk
  import noise_pkg::*;
#(
  parameter int CNT_W      = 22,
  parameter int ALIGN_W    = 8,
  parameter int LFSR_W     = 15,
  parameter int NARROW_BIT = 6
) (
  input logic               clk,
  input logic               rst_n,
  input logic               tick,
  input logic               trigWe,
  input logic [7:0]         trigData,
  input logic               noiseOut,
  input logic [CNT_W-1:0]   cntQ,
  input logic [CNT_W-1:0]   reloadVal,
  input logic [ALIGN_W-1:0] alignQ,
  input logic               phaseQ,
  input logic [LFSR_W-1:0]  lfsrQ,
  input lfsrCtl_t           ctl
);

  logic trigSeen;
  assign trigSeen = trigWe & trigData[7];

  AST_TRIG_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    trigSeen |=> noiseOut && (lfsrQ == '0)); // R2

  AST_STEP_RELOADS: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !trigSeen && cntQ == '0) |=> (cntQ == $past(reloadVal))); // R4

  AST_COUNT_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !trigSeen && cntQ != '0) |=> (cntQ == $past(cntQ) - CNT_W'(1))); // R4

  AST_PHASE_FLIPS: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> (phaseQ != $past(phaseQ))); // R5

  AST_ALIGN_ADVANCES: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> (alignQ == $past(alignQ) + ALIGN_W'(1))); // R6

  AST_NARROW_MIRROR: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl.step && ctl.narrow) |=> (lfsrQ[LFSR_W-1] == lfsrQ[NARROW_BIT])); // R8

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !trigSeen) |=> ($stable(lfsrQ) && $stable(cntQ) && $stable(phaseQ) && $stable(alignQ))); // R10

  AST_NO_STRAY_TRIG: assert property (@(posedge clk) disable iff (!rst_n)
    (trigWe && !trigData[7] && !tick) |=> $stable(lfsrQ) && $stable(cntQ)); // R3

endmodule

bind noise_gen noise_gen_chk #(
  .CNT_W(CNT_W), .ALIGN_W(ALIGN_W), .LFSR_W(LFSR_W), .NARROW_BIT(NARROW_BIT)
) u_chk (.*);

// File: tb/sim_noise_gen.sv
`timescale 1ns/1ps
module sim_noise_gen;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0;
  logic       freqWe = 1'b0;
  logic [7:0] freqData = 8'h00;
  logic       trigWe = 1'b0;
  logic [7:0] trigData = 8'h00;
  logic       chanActive = 1'b0;
  logic       noiseOut;

  int checks = 0;
  int fails = 0;
  int tickCount = 0;
  int cycles = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  noise_gen u0 (
    .clk(clk), .rst_n(rst_n), .tick(tick),
    .freqWe(freqWe), .freqData(freqData),
    .trigWe(trigWe), .trigData(trigData),
    .chanActive(chanActive), .noiseOut(noiseOut)
  );

  // ticks seen by the design since reset (counter and phase follow it)
  always @(posedge clk) begin
    if (rst_n && tick) tickCount <= tickCount + 1;
    cycles <= cycles + 1;
  end

  // {freq, newFreq, flags}; flags: b0 active, b1 tick gaps, b2 stray trigger,
  // b3 mid-run frequency rewrite, b5:4 tick counter [1:0] at the trigger
  localparam int NVEC = 11;
  localparam logic [23:0] VEC [NVEC] = '{
    24'h00_00_00, 24'h08_00_10, 24'h01_00_00, 24'h01_00_21,
    24'h12_00_00, 24'h23_00_32, 24'h1B_05_18, 24'h07_00_04,
    24'h0C_00_21, 24'h31_00_08, 24'h16_00_13
  };

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic int lenOf(input logic [7:0] f);
    int div;
    div = (f[2:0] == 3'd0) ? 1 : 2 * int'(f[2:0]);
    return (div << f[7:4]) - 1;
  endfunction

  function automatic int firstCount(input logic [7:0] f, input int tc, input bit act);
    int c;
    c = 2 * lenOf(f) + 6 - (1 ^ (tc & 1));
    if (f[2:0] != 3'd0 && ((tc >> 1) & 1) == 0) begin
      if (f[2:0] == 3'd1) c = c + 2;
      else                c = c - 2;
    end
    if (act) c = c + 2;
    return c;
  endfunction

  task automatic runVec(input logic [23:0] v);
    logic [7:0] f0;
    logic [7:0] f1;
    logic [7:0] fl;
    logic [7:0] fEff;
    int c0;
    int expTicks;
    int n;
    int iter;
    int steps;
    bit wasTick;
    f0 = v[23:16];
    f1 = v[15:8];
    fl = v[7:0];
    fEff = fl[3] ? f1 : f0;
    @(negedge clk);
    tick = 1'b1;
    freqWe = 1'b1; freqData = f0;
    @(negedge clk);
    freqWe = 1'b0;
    while ((tickCount & 3) != int'(fl[5:4])) @(negedge clk);
    chanActive = fl[0];
    c0 = firstCount(f0, tickCount, fl[0]);
    steps = fEff[3] ? 7 : 15;
    expTicks = (c0 + 1) + (steps - 1) * (4 * lenOf(fEff) + 4);
    trigWe = 1'b1; trigData = 8'h80;
    @(negedge clk);
    trigWe = 1'b0; trigData = 8'h00;
    chanActive = 1'b0;
    check(noiseOut == 1'b1, "R2 trigger clears register", int'(noiseOut), 1);
    n = 0;
    iter = 0;
    while (iter < 20000) begin
      if (fl[1]) tick = (iter % 3) != 1;
      if (iter == 0 && fl[3]) begin freqWe = 1'b1; freqData = f1; end
      else freqWe = 1'b0;
      if (iter == 1 && fl[2]) begin trigWe = 1'b1; trigData = 8'h7F; end
      else begin trigWe = 1'b0; trigData = 8'h00; end
      @(posedge clk);
      wasTick = tick;
      @(negedge clk);
      if (wasTick) n++;
      iter++;
      if (noiseOut == 1'b0) break;
    end
    freqWe = 1'b0; trigWe = 1'b0; trigData = 8'h00; tick = 1'b1;
    if (fl[1])      check(n == expTicks, "R10 R4 R5 R8 ticks to fall with gaps", n, expTicks);
    else if (fl[3]) check(n == expTicks, "R9 R4 R5 R8 ticks to fall after rewrite", n, expTicks);
    else if (fl[2]) check(n == expTicks, "R3 R4 R5 R8 ticks to fall with stray write", n, expTicks);
    else            check(n == expTicks, "R4 R5 R6 R7 R8 ticks to fall", n, expTicks);
  endtask

  task automatic finishRun();
    if (!finished) begin
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  endtask

  always @(negedge clk) begin
    if (cycles > 150000 && !finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog: got %0d cycles expected fewer than %0d", cycles, 150000);
      finishRun();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: reset leaves the register clear
    check(noiseOut == 1'b1, "R1 output after reset", int'(noiseOut), 1);
    // R10: with no ticks and no trigger the output cannot move
    repeat (20) @(negedge clk);
    check(noiseOut == 1'b1, "R10 idle without ticks", int'(noiseOut), 1);
    check(tickCount == 0, "R10 tick count idle", tickCount, 0);
    for (int i = 0; i < NVEC; i++) runVec(VEC[i]);
    finishRun();
  end

endmodule